// File: doc/BRIEF.md
# Up-Counting Event Timer Core

This block is a free-running up-counter that sits in the functional clock domain of a general-purpose timer. Configuration reaches it already synchronized: a 15-bit control word, a reload value, a compare value, a strobe that reloads the counter, and a strobe with data that writes the counter directly. From these it produces the live count, a captured copy of the count taken on edges of an input pin, a PWM output pin, and three event sources: compare match, overflow and capture.

Events set sticky status bits that software clears by writing ones. Two masks turn the status into a level interrupt and a level wake-up request. An optional power-of-two prescaler slows the count. Auto-reload turns the counter into a periodic timer. Without auto-reload it is a one-shot that halts after its first wrap. The PWM pin can toggle on each chosen event or give a pulse of one prescaled tick, both measured from a programmable idle level.

Top module: `tmr_core`

## Requirements
- R1: After reset the count, capture value, status, events, interrupt and wake-up outputs are all zero, and the PWM pin is 0.
- R2: Control bit 0 (start) set lets the counter advance. While it is clear, and no write or reload strobe is present, the count holds from the very next clock edge.
- R3: With control bit 5 clear the counter advances on every clock edge. With bit 5 set it advances once every 2^(P+1) edges, where P is control bits 4:2.
- R4: When the count wraps from all ones, status bit 1 (overflow) sets. With control bit 1 (auto-reload) set, the counter takes the reload value and keeps running. With it clear, the counter goes to 0 and stays there until start is cleared or the counter is written or reloaded.
- R5: A reload strobe copies the reload value into the counter whatever its data. A counter write sets the count to the written data, and a write wins over a reload in the same cycle.
- R6: With control bit 6 set, status bit 0 (match) sets when the counter advances to a value equal to the compare value. With bit 6 clear, no match is flagged.
- R7: Control bits 9:8 select the capture edge of the input pin: 00 none, 01 rising, 10 falling, 11 both. On a selected edge the current count is stored and status bit 2 (capture) sets.
- R8: With control bit 13 set, no new capture is taken while status bit 2 is still set.
- R9: Each status bit whose clear mask bit is 1 is cleared. An event arriving in the same cycle keeps its bit set.
- R10: The interrupt output is high when any status bit is set together with the same bit of the interrupt mask. The wake-up output does the same with the wake-up mask.
- R11: With control bit 12 set (toggle), the PWM pin inverts one cycle after a trigger event. Trigger select bits 11:10 are 01 for overflow and 10 for overflow or match.
- R12: With bit 12 clear (pulse), a trigger drives the pin to the inverse of control bit 7 from the next cycle until the next counter tick. With trigger select 00 or 11, the pin sits at the level of bit 7.
- R13: With control bit 14 set, the PWM output enable is low. With it clear, the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_i | input | 15 | Control word (bit fields as in the requirements) |
| load_val_i | input | 32 | Reload value |
| match_val_i | input | 32 | Compare value |
| trig_wr_i | input | 1 | Reload strobe: copy reload value into counter |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write data |
| stat_clr_i | input | 3 | Write-one-to-clear mask for status |
| int_en_i | input | 3 | Interrupt mask |
| wake_en_i | input | 3 | Wake-up mask |
| cap_pin_i | input | 1 | Synchronized capture input pin |
| cnt_o | output | 32 | Live count |
| cap_o | output | 32 | Captured count |
| evt_o | output | 3 | One-cycle raw events {capture, overflow, match} |
| stat_o | output | 3 | Sticky status {capture, overflow, match} |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | Level wake-up request |
| pwm_o | output | 1 | PWM pin level |
| pwm_oe_o | output | 1 | PWM pin output enable |

## Verification
Several rules are checked on every cycle by the assertions. The count freezes at the first edge after start is cleared. A prescaled tick never lands on two adjacent edges. An overflow always leaves its status bit set. A clear strobe with no competing event always empties its bit. A captured value stays fixed while capture is held pending. Other behaviour needs the bench's scenarios, which set up a state and then watch a sequence unfold. That covers the exact prescale spacing, the reload-versus-halt choice after a wrap, the edge selection, the set-over-clear race, the PWM toggle period and the width of a pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // control word, packed so that bit 0 is start and bit 14 is pin direction
    typedef struct packed {
        logic       pin_in;     // 14
        logic       cap_hold;   // 13
        logic       pwm_toggle; // 12
        logic [1:0] pwm_trig;   // 11:10
        logic [1:0] cap_edge;   // 9:8
        logic       pwm_def;    // 7
        logic       cmp_en;     // 6
        logic       pre_en;     // 5
        logic [2:0] ptv;        // 4:2
        logic       auto_rl;    // 1
        logic       start;      // 0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam int EV_MATCH = 0;
    localparam int EV_OVF   = 1;
    localparam int EV_CAP   = 2;
    localparam int EV_W     = 3;

    localparam logic [1:0] TRIG_NONE  = 2'b00;
    localparam logic [1:0] TRIG_OVF   = 2'b01;
    localparam logic [1:0] TRIG_OVFMT = 2'b10;

    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pre_en_i,
    input  logic [PTV_W-1:0] ptv_i,
    output logic             tick_o
);
    localparam int DIV_W = 2 ** PTV_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W-1:0] lim;

    // terminal value 2^(ptv+1)-1: ones in positions 0..ptv
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            lim[i] = (i <= int'(ptv_i));
        end
    end

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (!run_i) begin
            st_d.div = '0;
        end else if (!pre_en_i) begin
            tick_o   = 1'b1;
            st_d.div = '0;
        end else if (st_q.div == lim) begin
            tick_o   = 1'b1;
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a divided tick is never followed directly by another
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en_i && tick_o && run_i && pre_en_i) |=> !(tick_o && pre_en_i));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             hold_i,
    input  logic             pending_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] cap_o
);
    typedef struct packed {
        logic             pin_prev;
        logic [CNT_W-1:0] cap;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic rise, fall, hit;

    always_comb begin
        rise = pin_i && !st_q.pin_prev;
        fall = !pin_i && st_q.pin_prev;
        unique case (edge_sel_i)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise || fall;
            default:   hit = 1'b0;
        endcase
        fire_o        = hit && !(hold_i && pending_i);
        st_d          = st_q;
        st_d.pin_prev = pin_i;
        if (fire_o) st_d.cap = cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o = st_q.cap;

    assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && pending_i) |=> $stable(cap_o));

endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] trig_sel_i,
    input  logic       toggle_i,
    input  logic       def_i,
    input  logic       ovf_i,
    input  logic       match_i,
    input  logic       tick_i,
    output logic       pwm_o
);
    typedef struct packed {
        logic pin;
        logic pulse;
    } pwm_st_t;

    pwm_st_t st_d, st_q;
    logic trig;

    always_comb begin
        st_d = st_q;
        trig = ovf_i || ((trig_sel_i == TRIG_OVFMT) && match_i);
        if (trig_sel_i != TRIG_OVF && trig_sel_i != TRIG_OVFMT) begin
            st_d.pin   = def_i;
            st_d.pulse = 1'b0;
        end else if (toggle_i) begin
            st_d.pulse = 1'b0;
            if (trig) st_d.pin = !st_q.pin;
        end else if (trig) begin
            st_d.pin   = !def_i;
            st_d.pulse = 1'b1;
        end else if (!st_q.pulse || tick_i) begin
            st_d.pin   = def_i;
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pin;

    // a running pulse with no new trigger ends at the next tick
    assert_pulse_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && tick_i && !trig && !toggle_i) |=> (pwm_o == $past(def_i)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [14:0]      ctl_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] match_val_i,
    input  logic             trig_wr_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic [2:0]       stat_clr_i,
    input  logic [2:0]       int_en_i,
    input  logic [2:0]       wake_en_i,
    input  logic             cap_pin_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic [2:0]       evt_o,
    output logic [2:0]       stat_o,
    output logic             irq_o,
    output logic             wake_o,
    output logic             pwm_o,
    output logic             pwm_oe_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [EV_W-1:0]  evt;
        logic [EV_W-1:0]  stat;
        logic             halted;
    } core_st_t;

    core_st_t st_d, st_q;
    ctl_t     ctl;
    logic     run, tick, adv, wrap, cap_fire, match_fire;
    logic [CNT_W-1:0] cnt_next;

    assign ctl = ctl_t'(ctl_i);
    assign run = ctl.start && !st_q.halted;

    tmr_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .pre_en_i (ctl.pre_en),
        .ptv_i    (ctl.ptv[PTV_W-1:0]),
        .tick_o   (tick)
    );

    tmr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin_i),
        .edge_sel_i (ctl.cap_edge),
        .hold_i     (ctl.cap_hold),
        .pending_i  (st_q.stat[EV_CAP]),
        .cnt_i      (st_q.cnt),
        .fire_o     (cap_fire),
        .cap_o      (cap_o)
    );

    tmr_pwm u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_sel_i (ctl.pwm_trig),
        .toggle_i   (ctl.pwm_toggle),
        .def_i      (ctl.pwm_def),
        .ovf_i      (st_q.evt[EV_OVF]),
        .match_i    (st_q.evt[EV_MATCH]),
        .tick_i     (tick),
        .pwm_o      (pwm_o)
    );

    always_comb begin
        st_d       = st_q;
        adv        = run && tick && !cnt_wr_i && !trig_wr_i;
        wrap       = adv && (st_q.cnt == CNT_MAX);
        cnt_next   = wrap ? (ctl.auto_rl ? load_val_i : '0) : st_q.cnt + 1'b1;
        match_fire = adv && ctl.cmp_en && (cnt_next == match_val_i);

        if (cnt_wr_i)       st_d.cnt = cnt_wdata_i;
        else if (trig_wr_i) st_d.cnt = load_val_i;
        else if (adv)       st_d.cnt = cnt_next;

        if (cnt_wr_i || trig_wr_i || !ctl.start) st_d.halted = 1'b0;
        else if (wrap && !ctl.auto_rl)           st_d.halted = 1'b1;

        st_d.evt[EV_MATCH] = match_fire;
        st_d.evt[EV_OVF]   = wrap;
        st_d.evt[EV_CAP]   = cap_fire;
        st_d.stat          = (st_q.stat & ~stat_clr_i) | st_d.evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign evt_o    = st_q.evt;
    assign stat_o   = st_q.stat;
    assign irq_o    = |(st_q.stat & int_en_i);
    assign wake_o   = |(st_q.stat & wake_en_i);
    assign pwm_oe_o = !ctl.pin_in;

    assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i[0] && !cnt_wr_i && !trig_wr_i) |=> $stable(cnt_o));

    assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt_o == CNT_MAX && !cnt_wr_i && !trig_wr_i) |=> stat_o[EV_OVF]);

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_i[EV_OVF] && !(run && tick && cnt_o == CNT_MAX)) |=> !stat_o[EV_OVF]);

    assert_capture_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> stat_o[EV_CAP]);

endmodule

// File: tb/tb_tmr_core.sv
module tb_tmr_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ctl = '0;
    logic [31:0] load_val = '0, match_val = '0, cnt_wdata = '0;
    logic        trig_wr = 1'b0, cnt_wr = 1'b0, cap_pin = 1'b0;
    logic [2:0]  stat_clr = '0, int_en = '0, wake_en = '0;
    logic [31:0] cnt, cap;
    logic [2:0]  evt, stat;
    logic        irq, wake, pwm, pwm_oe;

    int n_run = 0, n_fail = 0;

    localparam logic [14:0] C_START = 15'h0001;
    localparam logic [14:0] C_AR    = 15'h0002;
    localparam logic [14:0] C_PRE   = 15'h0020;
    localparam logic [14:0] C_CE    = 15'h0040;
    localparam logic [14:0] C_DEF   = 15'h0080;
    localparam logic [14:0] C_RISE  = 15'h0100;
    localparam logic [14:0] C_FALL  = 15'h0200;
    localparam logic [14:0] C_BOTH  = 15'h0300;
    localparam logic [14:0] C_TOVF  = 15'h0400;
    localparam logic [14:0] C_TOG   = 15'h1000;
    localparam logic [14:0] C_HOLD  = 15'h2000;
    localparam logic [14:0] C_PIN   = 15'h4000;

    always #2.5 clk = !clk;

    tmr_core dut (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .load_val_i(load_val),
        .match_val_i(match_val), .trig_wr_i(trig_wr), .cnt_wr_i(cnt_wr),
        .cnt_wdata_i(cnt_wdata), .stat_clr_i(stat_clr), .int_en_i(int_en),
        .wake_en_i(wake_en), .cap_pin_i(cap_pin), .cnt_o(cnt), .cap_o(cap),
        .evt_o(evt), .stat_o(stat), .irq_o(irq), .wake_o(wake),
        .pwm_o(pwm), .pwm_oe_o(pwm_oe)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_cnt(input logic [31:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        step(1);
        cnt_wr = 1'b0;
    endtask

    task automatic clr_all();
        stat_clr = 3'b111; step(1); stat_clr = '0;
    endtask

    task automatic t_reset();
        chk("R1 cnt", cnt, 0); chk("R1 cap", cap, 0);
        chk("R1 stat", {29'd0, stat}, 0); chk("R1 evt", {29'd0, evt}, 0);
        chk("R1 irq/wake/pwm", {29'd0, irq, wake, pwm}, 0);
    endtask

    task automatic t_run_stop();
        wr_cnt(100);
        ctl = C_START; step(5);
        chk("R2 R3 runs each edge", cnt, 105);
        ctl = '0; step(3);
        chk("R2 held after stop", cnt, 105);
    endtask

    task automatic t_prescale();
        wr_cnt(0);
        ctl = C_START | C_PRE | (15'd1 << 2); // ratio 4
        step(7); chk("R3 prescale 7 edges", cnt, 1);
        step(1); chk("R3 prescale 8 edges", cnt, 2);
        ctl = '0; step(1);
    endtask

    task automatic t_overflow();
        load_val = 50;
        wr_cnt(32'hFFFF_FFFE);
        ctl = C_START | C_AR;
        step(2); chk("R4 reload on wrap", cnt, 50);
        chk("R4 overflow flag", {31'd0, stat[1]}, 1);
        step(1); chk("R4 keeps running", cnt, 51);
        stat_clr = 3'b010; step(1); stat_clr = '0;
        chk("R9 overflow cleared", {31'd0, stat[1]}, 0);
        ctl = '0; wr_cnt(32'hFFFF_FFFE);
        ctl = C_START;
        step(2); chk("R4 one-shot wraps to 0", cnt, 0);
        step(3); chk("R4 one-shot halted", cnt, 0);
        ctl = '0; step(1); ctl = C_START; step(2);
        chk("R4 restart after start cleared", cnt, 2);
        // set wins over clear
        ctl = '0; wr_cnt(32'hFFFF_FFFF);
        clr_all();
        ctl = C_START | C_AR; stat_clr = 3'b010; step(1); stat_clr = '0;
        chk("R9 event beats clear", {31'd0, stat[1]}, 1);
        ctl = '0; step(1);
    endtask

    task automatic t_trigger();
        load_val = 1234; trig_wr = 1'b1; step(1); trig_wr = 1'b0;
        chk("R5 reload strobe", cnt, 1234);
        trig_wr = 1'b1; cnt_wr = 1'b1; cnt_wdata = 7; step(1);
        trig_wr = 1'b0; cnt_wr = 1'b0;
        chk("R5 write beats reload", cnt, 7);
    endtask

    task automatic t_compare();
        clr_all(); match_val = 10;
        wr_cnt(8); ctl = C_START | C_CE;
        step(1); chk("R6 no match at 9", {31'd0, stat[0]}, 0);
        step(1); chk("R6 match at 10", {31'd0, stat[0]}, 1);
        ctl = '0; step(1);
        int_en = 3'b000; #0; chk("R10 irq masked", {31'd0, irq}, 0);
        int_en = 3'b001; #1; chk("R10 irq on match", {31'd0, irq}, 1);
        wake_en = 3'b100; #1; chk("R10 wake masked", {31'd0, wake}, 0);
        wake_en = 3'b001; #1; chk("R10 wake on match", {31'd0, wake}, 1);
        int_en = '0; wake_en = '0;
        clr_all(); wr_cnt(8); ctl = C_START;
        step(2); chk("R6 compare disabled", {31'd0, stat[0]}, 0);
        ctl = '0; step(1);
    endtask

    task automatic t_capture();
        logic [31:0] exp_cap;
        clr_all(); cap_pin = 1'b0; wr_cnt(200);
        ctl = C_START | C_RISE; step(3);
        exp_cap = cnt; cap_pin = 1'b1; step(1);
        chk("R7 rising capture", cap, exp_cap);
        chk("R7 capture flag", {31'd0, stat[2]}, 1);
        cap_pin = 1'b0; step(1);
        chk("R7 falling ignored in rise mode", cap, exp_cap);
        ctl = C_START | C_FALL; cap_pin = 1'b1; step(1);
        chk("R7 rising ignored in fall mode", cap, exp_cap);
        exp_cap = cnt; cap_pin = 1'b0; step(1);
        chk("R7 falling capture", cap, exp_cap);
        ctl = C_START; cap_pin = 1'b1; step(1); cap_pin = 1'b0; step(1);
        chk("R7 no edge selected", cap, exp_cap);
        // hold mode
        clr_all();
        ctl = C_START | C_BOTH | C_HOLD;
        exp_cap = cnt; cap_pin = 1'b1; step(1);
        chk("R8 first capture", cap, exp_cap);
        cap_pin = 1'b0; step(2);
        chk("R8 held while pending", cap, exp_cap);
        clr_all();
        exp_cap = cnt; cap_pin = 1'b1; step(1);
        chk("R8 capture after clear", cap, exp_cap);
        ctl = '0; cap_pin = 1'b0; step(1);
    endtask

    task automatic t_pwm();
        load_val = 32'hFFFF_FFFD; wr_cnt(32'hFFFF_FFFD);
        ctl = C_START | C_AR | C_TOG | C_TOVF;
        step(3); chk("R11 before first toggle", {31'd0, pwm}, 0);
        step(1); chk("R11 toggled after overflow", {31'd0, pwm}, 1);
        step(2); chk("R11 holds between events", {31'd0, pwm}, 1);
        step(1); chk("R11 toggled back", {31'd0, pwm}, 0);
        ctl = '0; step(1);
        wr_cnt(32'hFFFF_FFFD);
        ctl = C_START | C_AR | C_TOVF;
        step(3); chk("R12 idle before pulse", {31'd0, pwm}, 0);
        step(1); chk("R12 pulse active", {31'd0, pwm}, 1);
        step(1); chk("R12 pulse ends on next tick", {31'd0, pwm}, 0);
        ctl = C_DEF; step(1);
        chk("R12 default level with no trigger", {31'd0, pwm}, 1);
        chk("R13 output enabled", {31'd0, pwm_oe}, 1);
        ctl = C_PIN; #1;
        chk("R13 output disabled", {31'd0, pwm_oe}, 0);
        ctl = '0; step(1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_run_stop();
        t_prescale();
        t_overflow();
        t_trigger();
        t_compare();
        t_capture();
        t_pwm();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule